// File: doc/BRIEF.md
# Offset-Chained Multi-Tone Comb Generator

This block produces the sum of a comb of evenly spaced complex tones at one sample per clock, starting from only two phase-accumulator oscillators. One oscillator makes the base tone. The other makes a small spacing tone. Each further tone is the previous tone multiplied, as a complex number, by the spacing tone, so tone k sits at the base frequency plus k times the spacing. Each product stage takes three cycles. Every tone is delayed so that the whole comb is time-aligned. The active tones are then added, scaled and saturated into one I/Q output stream.

Software sets the two frequency words, the number of active tones and an output shift. The block captures them together on a single load strobe. The same strobe restarts both phase accumulators at zero, so every tone change is coherent and the comb restarts from a known phase.

Top module: `comb_tone_gen`

## Requirements
- R1: While reset is asserted and after it is released, with no load yet seen, both outputs are 0.
- R2: Each oscillator has a 32-bit phase accumulator that adds its frequency word every cycle. Sample n has phase n·F mod 2^32. Its value is (round(16383·cos(2πp/64)), round(16383·sin(2πp/64))), where p is phase bits [31:26]. Rounding is symmetric, away from zero at .5.
- R3: Tone 0 is the base oscillator sample. Tone k+1 is the complex product of tone k and the spacing sample of the same index. Each part of that product is floor((x·y − u·v)/2^14), or floor((x·v + u·y)/2^14) for the imaginary part, saturated to [−32768, 32767].
- R4: After the rising edge that samples load high, the output registered at the (n+30)-th following rising edge belongs to sample n (latency 3·(10−1)+3). All tones in that output come from the same sample index n.
- R5: Tones with index at or above the captured tone count contribute zero. A count of 0 silences both outputs. A count above 10 acts as 10.
- R6: The sum of the active tones is arithmetically shifted right by the captured shift, where values above 4 act as 4. The result is then saturated to [−32768, 32767].
- R7: The frequency words, the count and the shift take effect only in the cycle load is high. Changing these inputs without load leaves the output sequence unchanged.
- R8: A load clears both phase accumulators, so sample 0 after every load has phase 0 on both oscillators.
- R9: sum_i_o carries the sum of the real parts and sum_q_o carries the sum of the imaginary parts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture strobe for configuration; also restarts both phases |
| base_fcw_i | input | 32 | Base tone frequency word |
| step_fcw_i | input | 32 | Spacing tone frequency word |
| tone_cnt_i | input | 4 | Number of active tones, 0 to 10 |
| shift_i | input | 3 | Output right shift, 0 to 4 |
| sum_i_o | output | 16 | Scaled, saturated real sum of the comb |
| sum_q_o | output | 16 | Scaled, saturated imaginary sum of the comb |

## Verification
The assertions assume that load is a single-cycle pulse and that the configuration inputs are known whenever load is high. The bench drives every input at the falling edge and holds load high for exactly one cycle. The alignment assertion assumes that the spacing sample passed along the chain still matches the tone it meets. This holds only if each stage forwards the spacing sample with the same three-cycle latency as its product. The bench therefore tests alignment indirectly, with random base and spacing words that give each tone a distinct phase trajectory. It also changes the configuration inputs without load partway through a run, and applies out-of-range counts and shifts.

// File: rtl/comb_pkg.sv
package comb_pkg;
  localparam int SMP_W   = 16;
  localparam int FRAC    = SMP_W - 2;
  localparam int IDX_W   = 6;
  localparam int MUL_LAT = 3;

  typedef struct packed {
    logic signed [SMP_W-1:0] re;
    logic signed [SMP_W-1:0] im;
  } cplx_t;

  // quarter-wave amplitude, 17 points over 0..pi/2
  function automatic logic signed [SMP_W-1:0] qwave(logic [4:0] i);
    case (i)
      5'd0:  return 16'sd16383;
      5'd1:  return 16'sd16304;
      5'd2:  return 16'sd16068;
      5'd3:  return 16'sd15678;
      5'd4:  return 16'sd15136;
      5'd5:  return 16'sd14449;
      5'd6:  return 16'sd13622;
      5'd7:  return 16'sd12664;
      5'd8:  return 16'sd11585;
      5'd9:  return 16'sd10393;
      5'd10: return 16'sd9102;
      5'd11: return 16'sd7723;
      5'd12: return 16'sd6270;
      5'd13: return 16'sd4756;
      5'd14: return 16'sd3196;
      5'd15: return 16'sd1606;
      default: return 16'sd0;
    endcase
  endfunction

  function automatic cplx_t wave(logic [IDX_W-1:0] p);
    logic [4:0] r, rc;
    cplx_t w;
    r  = {1'b0, p[3:0]};
    rc = 5'd16 - r;
    case (p[5:4])
      2'd0:    begin w.re =  qwave(r);  w.im =  qwave(rc); end
      2'd1:    begin w.re = -qwave(rc); w.im =  qwave(r);  end
      2'd2:    begin w.re = -qwave(r);  w.im = -qwave(rc); end
      default: begin w.re =  qwave(rc); w.im = -qwave(r);  end
    endcase
    return w;
  endfunction

  function automatic logic signed [SMP_W-1:0] sat_smp(logic signed [2*SMP_W:0] v);
    if (v > (2*SMP_W+1)'(2**(SMP_W-1) - 1)) return {1'b0, {(SMP_W-1){1'b1}}};
    if (v < -(2*SMP_W+1)'(2**(SMP_W-1)))    return {1'b1, {(SMP_W-1){1'b0}}};
    return v[SMP_W-1:0];
  endfunction
endpackage

// File: rtl/comb_nco.sv
module comb_nco import comb_pkg::*; #(
  parameter int FCW_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [FCW_W-1:0] fcw_i,
  output cplx_t            tone_o
);
  logic [FCW_W-1:0] phase_q;
  cplx_t            tone_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      tone_q  <= '0;
    end else begin
      tone_q  <= wave(phase_q[FCW_W-1 -: IDX_W]);
      phase_q <= clr_i ? '0 : phase_q + fcw_i;
    end
  end

  assign tone_o = tone_q;

  // R8
  phase_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> phase_q == '0);
endmodule

// File: rtl/comb_cmul.sv
module comb_cmul import comb_pkg::*; (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  cplx_t a_i,
  input  cplx_t b_i,
  output cplx_t p_o,
  output cplx_t b_o
);
  localparam int PW = 2 * SMP_W;

  cplx_t a_q, b_q, b_d, b_o_q, p_q;
  logic signed [PW-1:0] rr_q, ii_q, ri_q, ir_q;
  logic signed [PW:0]   re_w, im_w;

  assign re_w = {rr_q[PW-1], rr_q} - {ii_q[PW-1], ii_q};
  assign im_w = {ri_q[PW-1], ri_q} + {ir_q[PW-1], ir_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0; b_q <= '0; b_d <= '0; b_o_q <= '0; p_q <= '0;
      rr_q <= '0; ii_q <= '0; ri_q <= '0; ir_q <= '0;
    end else begin
      a_q   <= a_i;
      b_q   <= b_i;
      rr_q  <= a_q.re * b_q.re;
      ii_q  <= a_q.im * b_q.im;
      ri_q  <= a_q.re * b_q.im;
      ir_q  <= a_q.im * b_q.re;
      b_d   <= b_q;
      p_q.re <= sat_smp(re_w >>> FRAC);
      p_q.im <= sat_smp(im_w >>> FRAC);
      b_o_q <= b_d;
    end
  end

  assign p_o = p_q;
  assign b_o = b_o_q;

  // R4 spacing sample leaves with the product's latency
  step_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_o == $past(b_i, MUL_LAT));
endmodule

// File: rtl/comb_delay.sv
module comb_delay #(
  parameter int W     = 32,
  parameter int DEPTH = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  if (DEPTH == 0) begin : g_pass
    assign d_o = d_i;
  end else begin : g_pipe
    logic [W-1:0] pipe_q [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) pipe_q[i] <= '0;
      end else begin
        pipe_q[0] <= d_i;
        for (int i = 1; i < DEPTH; i++) pipe_q[i] <= pipe_q[i-1];
      end
    end
    assign d_o = pipe_q[DEPTH-1];
  end
endmodule

// File: rtl/comb_tone_gen.sv
module comb_tone_gen import comb_pkg::*; #(
  parameter int N_TONES   = 10,
  parameter int FCW_W     = 32,
  parameter int OUT_W     = 16,
  parameter int CNT_W     = 4,
  parameter int SH_W      = 3,
  parameter int MAX_SHIFT = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [FCW_W-1:0]        base_fcw_i,
  input  logic [FCW_W-1:0]        step_fcw_i,
  input  logic [CNT_W-1:0]        tone_cnt_i,
  input  logic [SH_W-1:0]         shift_i,
  output logic signed [OUT_W-1:0] sum_i_o,
  output logic signed [OUT_W-1:0] sum_q_o
);
  localparam int SUM_W = SMP_W + $clog2(N_TONES) + 1;
  localparam logic signed [SUM_W-1:0] OUT_MAX = SUM_W'(2**(OUT_W-1) - 1);
  localparam logic signed [SUM_W-1:0] OUT_MIN = -SUM_W'(2**(OUT_W-1));

  logic [FCW_W-1:0] base_q, step_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SH_W-1:0]  shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0; step_q <= '0; cnt_q <= '0; shift_q <= '0;
    end else if (load_i) begin
      base_q  <= base_fcw_i;
      step_q  <= step_fcw_i;
      cnt_q   <= (tone_cnt_i > CNT_W'(N_TONES)) ? CNT_W'(N_TONES) : tone_cnt_i;
      shift_q <= (shift_i > SH_W'(MAX_SHIFT)) ? SH_W'(MAX_SHIFT) : shift_i;
    end
  end

  cplx_t tone [N_TONES];
  cplx_t stp  [N_TONES];
  cplx_t al   [N_TONES];

  comb_nco #(.FCW_W(FCW_W)) i_base_nco (
    .clk_i, .rst_ni, .clr_i(load_i), .fcw_i(base_q), .tone_o(tone[0]));
  comb_nco #(.FCW_W(FCW_W)) i_step_nco (
    .clk_i, .rst_ni, .clr_i(load_i), .fcw_i(step_q), .tone_o(stp[0]));

  for (genvar k = 0; k < N_TONES - 1; k++) begin : g_chain
    comb_cmul i_cmul (
      .clk_i, .rst_ni, .a_i(tone[k]), .b_i(stp[k]), .p_o(tone[k+1]), .b_o(stp[k+1]));
  end

  // align every tone to the end of the chain
  for (genvar k = 0; k < N_TONES; k++) begin : g_align
    comb_delay #(.W(2*SMP_W), .DEPTH(MUL_LAT*(N_TONES-1-k))) i_dly (
      .clk_i, .rst_ni, .d_i(tone[k]), .d_o(al[k]));
  end

  logic signed [SUM_W-1:0] acc_re, acc_im, sum_re_q, sum_im_q;
  logic signed [SUM_W-1:0] sc_re, sc_im;

  always_comb begin
    acc_re = '0;
    acc_im = '0;
    for (int k = 0; k < N_TONES; k++) begin
      if (CNT_W'(k) < cnt_q) begin
        acc_re = acc_re + SUM_W'(al[k].re);
        acc_im = acc_im + SUM_W'(al[k].im);
      end
    end
  end

  assign sc_re = sum_re_q >>> shift_q;
  assign sc_im = sum_im_q >>> shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_re_q <= '0; sum_im_q <= '0; sum_i_o <= '0; sum_q_o <= '0;
    end else begin
      sum_re_q <= acc_re;
      sum_im_q <= acc_im;
      sum_i_o  <= (sc_re > OUT_MAX) ? OUT_MAX[OUT_W-1:0] :
                  (sc_re < OUT_MIN) ? OUT_MIN[OUT_W-1:0] : sc_re[OUT_W-1:0];
      sum_q_o  <= (sc_im > OUT_MAX) ? OUT_MAX[OUT_W-1:0] :
                  (sc_im < OUT_MIN) ? OUT_MIN[OUT_W-1:0] : sc_im[OUT_W-1:0];
    end
  end

  // alignment: the aligned tone 1 must be aligned tone 0 times the spacing sample leaving the chain
  logic signed [2*SMP_W:0] al_re_w;
  assign al_re_w = (2*SMP_W+1)'(al[0].re * stp[N_TONES-1].re)
                 - (2*SMP_W+1)'(al[0].im * stp[N_TONES-1].im);

  // R4
  align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    al[1].re == sat_smp(al_re_w >>> FRAC));

  // R7
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(base_q) && $stable(step_q) && $stable(cnt_q) && $stable(shift_q));

  // R7
  cfg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> base_q == $past(base_fcw_i) && step_q == $past(step_fcw_i));

  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(N_TONES));

  // R5
  silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == '0 |=> sum_re_q == '0 && sum_im_q == '0);

  // R6
  sign_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sum_re_q[SUM_W-1]) |-> !sum_i_o[OUT_W-1]);
endmodule

// File: tb/test_comb_tone_gen.sv
module test_comb_tone_gen;
  localparam int NT  = 10;
  localparam int LAT = 3 * (NT - 1) + 3;
  localparam real PI = 3.14159265358979323846;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [31:0] base_fcw = '0, step_fcw = '0;
  logic [3:0]  tone_cnt = '0;
  logic [2:0]  shift = '0;
  logic signed [15:0] sum_i, sum_q;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  longint m_base, m_step, m_cnt, m_sh;

  always #4 clk = ~clk;

  comb_tone_gen i_comb_tone_gen (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load),
    .base_fcw_i(base_fcw), .step_fcw_i(step_fcw),
    .tone_cnt_i(tone_cnt), .shift_i(shift),
    .sum_i_o(sum_i), .sum_q_o(sum_q));

  function automatic longint rnd(real x);
    if (x >= 0.0) return longint'($floor(x + 0.5));
    return -longint'($floor(-x + 0.5));
  endfunction

  function automatic longint sat(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // R2 oscillator sample
  function automatic void osc(longint fcw, int n, output longint re, output longint im);
    longint ph, p;
    ph = (longint'(n) * fcw) & 64'hFFFF_FFFF;
    p  = ph >> 26;
    re = rnd(16383.0 * $cos(2.0 * PI * real'(p) / 64.0));
    im = rnd(16383.0 * $sin(2.0 * PI * real'(p) / 64.0));
  endfunction

  // R3..R6, R9 expected output for sample n
  function automatic void model(int n, output longint er, output longint ei);
    longint tr, ti, sr, si, nr, ni, ar, ai;
    osc(m_base, n, tr, ti);
    osc(m_step, n, sr, si);
    ar = 0; ai = 0;
    for (int k = 0; k < NT; k++) begin
      if (k < m_cnt) begin ar += tr; ai += ti; end
      nr = sat((tr * sr - ti * si) >>> 14);
      ni = sat((tr * si + ti * sr) >>> 14);
      tr = nr; ti = ni;
    end
    er = sat(ar >>> m_sh);
    ei = sat(ai >>> m_sh);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // load a configuration, then check nsamp aligned samples; optionally disturb inputs without load
  task automatic run_cfg(logic [31:0] b, logic [31:0] s, logic [3:0] c, logic [2:0] sh,
                         int nsamp, bit disturb, string req);
    longint er, ei;
    int m;
    @(negedge clk);
    base_fcw = b; step_fcw = s; tone_cnt = c; shift = sh; load = 1'b1;
    @(posedge clk);
    m_base = b; m_step = s;
    m_cnt  = (c > 10) ? 10 : c;
    m_sh   = (sh > 4) ? 4 : sh;
    @(negedge clk);
    load = 1'b0;
    m = 0;
    while (m < LAT + nsamp) begin
      @(posedge clk);
      m++;
      @(negedge clk);
      if (disturb && m == LAT + 4) begin
        base_fcw = $urandom; step_fcw = $urandom; tone_cnt = 4'd3; shift = 3'd1;
      end
      if (m >= LAT) begin
        model(m - LAT, er, ei);
        chk(longint'(sum_i) == er, {req, " I"}, longint'(sum_i), er);
        chk(longint'(sum_q) == ei, {req, " Q"}, longint'(sum_q), ei);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(sum_i == 0 && sum_q == 0, "R1 in reset", longint'(sum_i), 0);
    rst_n = 1'b1;
    repeat (LAT + 5) begin
      @(negedge clk);
      chk(sum_i == 0 && sum_q == 0, "R1 after reset", longint'(sum_i), 0);
    end

    // R2 R3 R4 R9: one, five and ten tones
    run_cfg(32'h0400_0000, 32'h0100_0000, 4'd1, 3'd0, 40, 1'b0, "R2 one tone");
    run_cfg(32'h0280_0000, 32'h0080_0000, 4'd5, 3'd2, 40, 1'b0, "R3 five tones");
    run_cfg(32'h0123_4567, 32'h0034_5678, 4'd10, 3'd4, 60, 1'b0, "R4 ten tones");
    // R5: silent and clamped count
    run_cfg(32'h0400_0000, 32'h0100_0000, 4'd0, 3'd0, 20, 1'b0, "R5 zero count");
    run_cfg(32'h0555_0000, 32'h0033_0000, 4'd15, 3'd4, 30, 1'b0, "R5 count clamp");
    // R6: saturation and clamped shift
    run_cfg(32'h0, 32'h0, 4'd10, 3'd0, 20, 1'b0, "R6 saturation");
    run_cfg(32'h0, 32'h0, 4'd10, 3'd7, 20, 1'b0, "R6 shift clamp");
    // R7: inputs move without load
    run_cfg(32'h0312_0000, 32'h0041_0000, 4'd6, 3'd3, 50, 1'b1, "R7 hold without load");
    // R8: reload same words mid-stream restarts phase
    run_cfg(32'h0312_0000, 32'h0041_0000, 4'd6, 3'd3, 30, 1'b0, "R8 phase restart");
    // random mix
    for (int i = 0; i < 8; i++) begin
      run_cfg($urandom, $urandom, 4'(1 + ($urandom % 10)), 3'($urandom % 5), 40, 1'b0,
              "R3 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule